// File: doc/BRIEF.md
# Trap and Interrupt Priority Controller

This block takes service requests from a set of peripherals and hands out one grant at a time. A request is either an interrupt or a trap. An interrupt makes the CPU fetch its next instruction from a location that the winning device supplies. A trap steals memory cycles: one word moves between memory and the device while the program sequencer is held.

Arbitration does not happen on every core clock. It happens only on a slow slot strobe, produced once every `TICK_DIV` core cycles. Between strobes, requests are not examined. A trap holds the program for exactly `TRAP_TICKS` slot periods. During that window the block performs one memory access at the address the device places on the shared address bus. A trap direction bit chooses a read or a write. An interrupt grant lasts one slot period. It ends with a one-cycle vector pulse that carries the device's location.

Top module: `svc_prio_ctrl`

## Requirements
- R1: After reset, `grant` is zero and `stall`, `mem_en` and `vec_valid` are low.
- R2: `grant` changes only in the cycle after a cycle where `slot_tick` was high. `slot_tick` is high for one cycle in every `TICK_DIV` cycles.
- R3: Among requests of the same kind seen at one slot, the lowest index wins. `grant` is one-hot, with bit i meaning device i.
- R4: When trap and interrupt requests are both pending at one slot, a trap wins, whatever the indices.
- R5: A trap grant keeps `grant` and `stall` high for exactly `TRAP_TICKS*TICK_DIV` consecutive cycles, starting the cycle after the arbitrating slot.
- R6: A trap whose `trap_dir` bit is 1 writes `dev_wdata` into memory at `dev_addr`. Each trap issues exactly one single-cycle `mem_en` pulse, and that pulse falls inside the stall window.
- R7: A trap whose `trap_dir` bit is 0 reads memory at `dev_addr`. The word is on `dev_rdata` by the end of the window and stays there until the next trap read.
- R8: An interrupt grant lasts one slot period without `stall`. When it ends, `vec_valid` pulses for one cycle and `vec_addr` carries `dev_addr`.
- R9: If a trap request is present at a slot while nothing is granted, the trap is granted in the next cycle.
- R10: A request that rises and falls between two slots produces no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_DEV | Interrupt request, one per device |
| trap_req | input | N_DEV | Trap request, one per device |
| trap_dir | input | N_DEV | Per-device trap direction: 1 device-to-memory, 0 memory-to-device |
| dev_addr | input | ADDR_W | Address driven by the granted device |
| dev_wdata | input | DATA_W | Word from the granted device for a trap write |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after `mem_en` |
| slot_tick | output | 1 | Arbitration slot strobe |
| grant | output | N_DEV | One-hot grant |
| stall | output | 1 | Holds the CPU sequencer during a trap |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| dev_rdata | output | DATA_W | Word read for the device |
| vec_valid | output | 1 | Interrupt vector pulse |
| vec_addr | output | ADDR_W | Location for the CPU to execute |

## Verification
A corrupted state register shows up at the ports within one slot period. A wrong state or tick count changes the length of the stall window, or makes `grant` move away from a slot boundary. A wrong winner register grants the wrong bit in the cycle right after the arbitrating slot. A lost direction or address gives the wrong memory word or the wrong `dev_rdata`, and that is visible as soon as the window closes. A broken vector path shows up at the closing slot of an interrupt grant, as a missing or misplaced `vec_valid`.

// File: rtl/svc_prio_pkg.sv
package svc_prio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TRAP = 2'd1,
        ST_INTR = 2'd2
    } svc_state_e;

endpackage

// File: rtl/svc_slot_timer.sv
module svc_slot_timer #(
    parameter int TICK_DIV = 9
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt == CW'(TICK_DIV - 1)) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign tick = (tmr_q.cnt == CW'(TICK_DIV - 1));

endmodule

// File: rtl/svc_prio_pick.sv
module svc_prio_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] win,
    output logic         any
);
    logic [N-1:0] lower_seen;

    assign lower_seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i > 0) begin : g_chain
            assign lower_seen[i] = lower_seen[i-1] | req[i-1];
        end
        assign win[i] = req[i] & ~lower_seen[i];
    end

    assign any = |req;

endmodule

// File: rtl/svc_prio_ctrl.sv
module svc_prio_ctrl
    import svc_prio_pkg::*;
#(
    parameter int N_DEV      = 8,
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 16,
    parameter int TICK_DIV   = 9,
    parameter int TRAP_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DEV-1:0]  irq_req,
    input  logic [N_DEV-1:0]  trap_req,
    input  logic [N_DEV-1:0]  trap_dir,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              slot_tick,
    output logic [N_DEV-1:0]  grant,
    output logic              stall,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] dev_rdata,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr
);
    localparam int TL_W = $clog2(TRAP_TICKS + 1);

    typedef struct packed {
        svc_state_e        st;
        logic [N_DEV-1:0]  grant;
        logic              dir;
        logic [TL_W-1:0]   ticks_left;
        logic              issued;
        logic              mem_en;
        logic              mem_we;
        logic [ADDR_W-1:0] mem_addr;
        logic [DATA_W-1:0] mem_wdata;
        logic              rd_cap;
        logic [DATA_W-1:0] rdata;
        logic              vec_valid;
        logic [ADDR_W-1:0] vec_addr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             tick;
    logic [N_DEV-1:0] trap_win, irq_win;
    logic             trap_any, irq_any;

    svc_slot_timer #(
        .TICK_DIV(TICK_DIV)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    svc_prio_pick #(
        .N(N_DEV)
    ) u_pick_trap (
        .req(trap_req),
        .win(trap_win),
        .any(trap_any)
    );

    svc_prio_pick #(
        .N(N_DEV)
    ) u_pick_irq (
        .req(irq_req),
        .win(irq_win),
        .any(irq_any)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.mem_en    = 1'b0;
        ctl_d.vec_valid = 1'b0;
        // Read data arrives one cycle after the strobe.
        ctl_d.rd_cap    = ctl_q.mem_en & ~ctl_q.mem_we;
        if (ctl_q.rd_cap) begin
            ctl_d.rdata = mem_rdata;
        end

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (tick) begin
                    if (trap_any) begin
                        ctl_d.st         = ST_TRAP;
                        ctl_d.grant      = trap_win;
                        ctl_d.dir        = |(trap_win & trap_dir);
                        ctl_d.ticks_left = TL_W'(TRAP_TICKS);
                        ctl_d.issued     = 1'b0;
                    end else if (irq_any) begin
                        ctl_d.st    = ST_INTR;
                        ctl_d.grant = irq_win;
                    end
                end
            end
            ST_TRAP: begin
                if (tick) begin
                    ctl_d.ticks_left = ctl_q.ticks_left - TL_W'(1);
                    if (!ctl_q.issued) begin
                        ctl_d.issued    = 1'b1;
                        ctl_d.mem_en    = 1'b1;
                        ctl_d.mem_we    = ctl_q.dir;
                        ctl_d.mem_addr  = dev_addr;
                        ctl_d.mem_wdata = dev_wdata;
                    end
                    if (ctl_q.ticks_left == TL_W'(1)) begin
                        ctl_d.st    = ST_IDLE;
                        ctl_d.grant = '0;
                    end
                end
            end
            ST_INTR: begin
                if (tick) begin
                    ctl_d.st        = ST_IDLE;
                    ctl_d.grant     = '0;
                    ctl_d.vec_valid = 1'b1;
                    ctl_d.vec_addr  = dev_addr;
                end
            end
            default: begin
                ctl_d.st    = ST_IDLE;
                ctl_d.grant = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign slot_tick = tick;
    assign grant     = ctl_q.grant;
    assign stall     = (ctl_q.st == ST_TRAP);
    assign mem_en    = ctl_q.mem_en;
    assign mem_we    = ctl_q.mem_we;
    assign mem_addr  = ctl_q.mem_addr;
    assign mem_wdata = ctl_q.mem_wdata;
    assign dev_rdata = ctl_q.rdata;
    assign vec_valid = ctl_q.vec_valid;
    assign vec_addr  = ctl_q.vec_addr;

endmodule

// File: rtl/svc_prio_ctrl_chk.sv
module svc_prio_ctrl_chk #(
    parameter int N_DEV      = 8,
    parameter int TICK_DIV   = 9,
    parameter int TRAP_TICKS = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slot_tick,
    input logic [N_DEV-1:0] trap_req,
    input logic [N_DEV-1:0] grant,
    input logic             stall,
    input logic             mem_en,
    input logic             vec_valid
);
    localparam int WIN = TRAP_TICKS * TICK_DIV;

    int unsigned run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 0;
        end else if (stall) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    a_r2_grant_on_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != $past(grant)) |-> $past(slot_tick));

    a_r3_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r5_stall_has_grant: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (grant != '0));

    a_r5_window_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> (run_q == WIN));

    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> !mem_en);

    a_r6_strobe_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> stall);

    a_r8_vector_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (!stall && grant == '0 && $past(grant) != '0));

    a_r9_idle_trap_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && slot_tick && (|trap_req)) |=> (stall && grant != '0));

endmodule

bind svc_prio_ctrl svc_prio_ctrl_chk #(
    .N_DEV     (N_DEV),
    .TICK_DIV  (TICK_DIV),
    .TRAP_TICKS(TRAP_TICKS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_tick(slot_tick),
    .trap_req (trap_req),
    .grant    (grant),
    .stall    (stall),
    .mem_en   (mem_en),
    .vec_valid(vec_valid)
);

// File: tb/svc_prio_ctrl_bench.sv
module svc_prio_ctrl_bench;
    localparam int N  = 8;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int D  = 9;
    localparam int TT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic [N-1:0]  trap_req = '0;
    logic [N-1:0]  trap_dir = '0;
    logic [AW-1:0] dev_addr;
    logic [DW-1:0] dev_wdata;
    logic [DW-1:0] mem_rdata;
    logic          slot_tick;
    logic [N-1:0]  grant;
    logic          stall;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] dev_rdata;
    logic          vec_valid;
    logic [AW-1:0] vec_addr;

    logic [DW-1:0] mem_model [0:(1<<AW)-1];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    svc_prio_ctrl #(
        .N_DEV(N), .ADDR_W(AW), .DATA_W(DW), .TICK_DIV(D), .TRAP_TICKS(TT)
    ) u_svc_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .trap_req(trap_req),
        .trap_dir(trap_dir), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
        .mem_rdata(mem_rdata), .slot_tick(slot_tick), .grant(grant),
        .stall(stall), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .dev_rdata(dev_rdata), .vec_valid(vec_valid),
        .vec_addr(vec_addr)
    );

    function automatic logic [AW-1:0] base_of(int i);
        return AW'(10'h040 + i * 37);
    endfunction

    function automatic logic [DW-1:0] word_of(int i);
        return DW'(16'hA500 + i * 16'h0111);
    endfunction

    function automatic int expect_winner(logic [N-1:0] t, logic [N-1:0] q);
        for (int i = 0; i < N; i++) if (t[i]) return i;
        for (int i = 0; i < N; i++) if (q[i]) return i;
        return -1;
    endfunction

    // Device side: the granted device drives its address and data.
    always_comb begin
        dev_addr  = '0;
        dev_wdata = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                dev_addr  = base_of(i);
                dev_wdata = word_of(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem_model[mem_addr] <= mem_wdata;
            mem_rdata <= mem_model[mem_addr];
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic to_tick();
        @(negedge clk);
        while (!slot_tick) @(negedge clk);
    endtask

    // Requests are set up; arbitrate at the next slot and serve.
    task automatic serve(logic [N-1:0] t, logic [N-1:0] q, logic [N-1:0] dr);
        int w;
        int cnt;
        bit is_trap;
        w = expect_winner(t, q);
        is_trap = (t != '0);
        for (int i = 0; i < N; i++) mem_model[base_of(i)] = DW'(16'h3C00 + i);
        to_tick();
        trap_req = t;
        irq_req  = q;
        trap_dir = dr;
        @(negedge clk);
        trap_req = '0;
        irq_req  = '0;
        check(grant == (N'(1) << w), is_trap ? "R3/R4/R9 trap winner" : "R3 irq winner",
              int'(grant), int'(N'(1) << w));
        if (is_trap) begin
            cnt = 1;
            check(stall == 1'b1, "R5 stall raised", int'(stall), 1);
            while (stall && cnt < 4 * TT * D) begin
                @(negedge clk);
                if (stall) cnt++;
            end
            check(cnt == TT * D, "R5 window length", cnt, TT * D);
            check(grant == '0, "R5 grant released", int'(grant), 0);
            if (dr[w]) begin
                check(mem_model[base_of(w)] == word_of(w), "R6 trap write",
                      int'(mem_model[base_of(w)]), int'(word_of(w)));
            end else begin
                check(dev_rdata == DW'(16'h3C00 + w), "R7 trap read",
                      int'(dev_rdata), 16'h3C00 + w);
                check(mem_model[base_of(w)] == DW'(16'h3C00 + w), "R7 memory untouched",
                      int'(mem_model[base_of(w)]), 16'h3C00 + w);
            end
        end else begin
            for (int k = 1; k < D; k++) begin
                @(negedge clk);
                if (stall || vec_valid) check(1'b0, "R8 no stall during interrupt",
                                              int'({stall, vec_valid}), 0);
            end
            @(negedge clk);
            check(vec_valid == 1'b1, "R8 vector pulse", int'(vec_valid), 1);
            check(vec_addr == base_of(w), "R8 vector address", int'(vec_addr), int'(base_of(w)));
            check(grant == '0, "R8 grant released", int'(grant), 0);
            @(negedge clk);
            check(vec_valid == 1'b0, "R8 pulse one cycle", int'(vec_valid), 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(grant == '0 && !stall && !mem_en && !vec_valid, "R1 reset outputs",
              int'({grant, stall, mem_en, vec_valid}), 0);
        rst_n = 1'b1;

        // R2: slot strobe period.
        to_tick();
        begin
            int gap = 0;
            @(negedge clk);
            gap = 1;
            while (!slot_tick && gap < 4 * D) begin
                @(negedge clk);
                gap++;
            end
            check(gap == D, "R2 slot period", gap, D);
        end

        serve(8'h00, 8'h01, 8'h00);            // R8 single interrupt
        serve(8'h44, 8'h00, 8'h04);            // R3 trap 2 over 6, write
        serve(8'h20, 8'h01, 8'h00);            // R4 trap 5 beats irq 0, read
        serve(8'h00, 8'hA0, 8'h00);            // R3 irq 5 over 7
        serve(8'h80, 8'h00, 8'h80);            // R6 highest index write

        // R10: pulse between slots is ignored.
        to_tick();
        @(negedge clk);
        trap_req = 8'h08;
        irq_req  = 8'h10;
        @(negedge clk);
        trap_req = '0;
        irq_req  = '0;
        to_tick();
        @(negedge clk);
        check(grant == '0 && !stall, "R10 pulse ignored", int'(grant), 0);

        // R2: a request raised mid-period waits for the slot.
        @(negedge clk);
        trap_req = 8'h02;
        @(negedge clk);
        check(grant == '0, "R2 no grant before slot", int'(grant), 0);
        trap_req = '0;

        for (int it = 0; it < 30; it++) begin
            logic [N-1:0] t, q, dr;
            t  = N'($urandom) & N'($urandom);
            q  = N'($urandom);
            dr = N'($urandom);
            if (t == '0 && q == '0) q = 8'h40;
            serve(t, q, dr);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule